// File: doc/BRIEF.md
# Vendor Write-Command Receive Admission Controller

This block sits on the target side of a two-wire command bus. It handles vendor-specific write commands, both the kind sent to one address and the kind sent to all targets. A front end decodes bus events and presents them as single-cycle pulses: a command start with its code and a directed flag, an optional defining byte, data bytes with a parity-error flag, a termination (STOP or RESTART), and a status-read command. For each start, the block decides whether to accept it. Accepted payload goes into an internal receive FIFO. At termination, one response entry is pushed into a response queue.

The application drains both queues through valid/ready pop ports. An item is removed on a cycle where valid and ready are both high. While ready is low, the head item and its valid stay unchanged. Back-pressure on the receive FIFO reduces the free space that admission sees. Back-pressure on the response queue can make it full, which also blocks admission.

There are three sticky status bits: overflow, protocol error and buffer unavailable. Overflow and protocol error lock the block out of accepting writes. The lockout ends only when a status read is seen and software then gives a resume pulse. A level-based DMA request tells the application when to move data out of the FIFO.

Top module: `vrx_wccc_rx`

## Requirements
- R1: A start is accepted, shown by `start_ack` high for one cycle, one cycle after `ev_start`, only when all of these hold: the FIFO free space (depth minus fill level) is at least `cfg_start_thld`, the response queue is not full, `st_buf_unavail` is clear, and neither the overflow nor the protocol-error bit is set.
- R2: A directed start that is not accepted gives a one-cycle `start_nack`. A broadcast start that is not accepted gives neither `start_ack` nor `start_nack`. Its bytes do not reach the FIFO, and it produces no response entry.
- R3: A refused start whose free space is below `cfg_start_thld` sets `st_buf_unavail`, unless a lockout is already active. The bit clears once the free space reaches the threshold again.
- R4: A byte that arrives while the FIFO is full sets `st_overflow`. That byte and every later byte of the same transfer are discarded.
- R5: A byte or defining byte flagged with a parity error sets `st_proto_err`. That byte and every later byte of the same transfer are discarded.
- R6: While `st_overflow` or `st_proto_err` is set, every start is refused. Both bits clear only on a `sw_resume` pulse that comes after an `ev_getstatus` seen during the lockout. A resume pulse given before that has no effect.
- R7: Each accepted transfer pushes one response entry at `ev_stop`. The entry holds the command code and the number of bytes written to the FIFO. For a directed command, it also holds the defining byte, with `resp_has_def` set to 1.
- R8: For a broadcast command, the defining byte is written to the FIFO as ordinary payload and is counted in the length. `resp_has_def` is 0.
- R9: `dma_req` is high exactly while the FIFO fill level is at least `cfg_rx_thld`.
- R10: The receive pop port delivers bytes in arrival order. It holds `rx_data` and `rx_valid` steady while `rx_ready` is low.
- R11: The response pop port delivers entries in order and holds them steady while `resp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Command start pulse |
| ev_directed | input | 1 | 1 = directed, 0 = broadcast (valid with ev_start) |
| ev_code | input | 8 | Command code (valid with ev_start) |
| ev_def_valid | input | 1 | Defining byte on ev_byte |
| ev_byte_valid | input | 1 | Data byte on ev_byte |
| ev_byte | input | 8 | Byte value |
| ev_parity_err | input | 1 | Parity error on the current byte |
| ev_stop | input | 1 | STOP or RESTART seen |
| ev_getstatus | input | 1 | Status-read command seen |
| sw_resume | input | 1 | Software resume pulse |
| cfg_start_thld | input | LW | Minimum free entries needed for admission |
| cfg_rx_thld | input | LW | Fill level that raises dma_req |
| start_ack | output | 1 | Start accepted |
| start_nack | output | 1 | Directed start refused |
| rx_valid | output | 1 | FIFO head valid |
| rx_ready | input | 1 | Application takes FIFO head |
| rx_data | output | 8 | FIFO head byte |
| resp_valid | output | 1 | Response head valid |
| resp_ready | input | 1 | Application takes response head |
| resp_code | output | 8 | Command code |
| resp_defb | output | 8 | Defining byte (directed) |
| resp_has_def | output | 1 | Defining byte present in entry |
| resp_len | output | LEN_W | Bytes written to FIFO |
| st_overflow | output | 1 | Sticky overflow |
| st_proto_err | output | 1 | Sticky parity/protocol error |
| st_buf_unavail | output | 1 | Buffer-unavailable status |
| dma_req | output | 1 | Fill level at or above cfg_rx_thld |

## Verification
The bench runs clean transfers of both kinds to check where the defining byte goes, and whether it is counted in the length. It fills the FIFO under back-pressure, to tell a refusal for lack of space apart from a refusal for a full response queue. It also sends one transfer longer than the FIFO and one with a parity error in the middle. These show that data stops at the right byte and that the lockout only ends after a status read followed by a resume. A resume given before the status read is included to show that it is ignored. A level sweep shows the exact fill level at which `dma_req` turns on.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int VRX_LEN_W = 12;

  typedef struct packed {
    logic [7:0]           code;
    logic [7:0]           defb;
    logic                 has_def;
    logic [VRX_LEN_W-1:0] len;
  } vrx_resp_t;

  localparam int VRX_RESP_W = $bits(vrx_resp_t);
endpackage

// File: rtl/vrx_fifo.sv
module vrx_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          full,
  output logic          valid,
  input  logic          ready,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign valid   = (level != '0);
  assign dout    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = valid && ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_FIFO_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout))); // R10
endmodule

// File: rtl/vrx_admit.sv
module vrx_admit
  import vrx_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  localparam int LW = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_start,
  input  logic            ev_directed,
  input  logic [7:0]      ev_code,
  input  logic            ev_def_valid,
  input  logic            ev_byte_valid,
  input  logic [7:0]      ev_byte,
  input  logic            ev_parity_err,
  input  logic            ev_stop,
  input  logic            ev_getstatus,
  input  logic            sw_resume,
  input  logic [LW-1:0]   cfg_start_thld,
  input  logic [LW-1:0]   rx_level,
  input  logic            rx_full,
  input  logic            resp_full,
  output logic            rx_push,
  output logic [7:0]      rx_din,
  output logic            resp_push,
  output vrx_resp_t       resp_din,
  output logic            start_ack,
  output logic            start_nack,
  output logic            st_overflow,
  output logic            st_proto_err,
  output logic            st_buf_unavail
);
  logic                 active, dir_q, drop_q, gs_seen;
  logic [7:0]           code_q, defb_q;
  logic                 has_def_q;
  logic [VRX_LEN_W-1:0] len_q;
  logic [LW-1:0]        free_sp;
  logic                 space_ok, lock, admit, bufna_set;
  logic                 byte_in, any_in, perr_hit, ovf_hit;

  assign free_sp   = LW'(RX_DEPTH) - rx_level;
  assign space_ok  = (free_sp >= cfg_start_thld);
  assign lock      = st_overflow || st_proto_err;
  assign admit     = space_ok && !resp_full && !lock && !st_buf_unavail;
  assign bufna_set = ev_start && !admit && !space_ok && !lock;

  // broadcast defining byte travels as payload
  assign byte_in  = ev_byte_valid || (ev_def_valid && !dir_q);
  assign any_in   = active && !drop_q && (ev_byte_valid || ev_def_valid);
  assign perr_hit = any_in && ev_parity_err;
  assign ovf_hit  = active && !drop_q && byte_in && !ev_parity_err && rx_full;
  assign rx_push  = active && !drop_q && byte_in && !ev_parity_err && !rx_full;
  assign rx_din   = ev_byte;

  assign resp_push = active && ev_stop;
  assign resp_din  = '{code: code_q, defb: defb_q, has_def: has_def_q, len: len_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; dir_q <= 1'b0; drop_q <= 1'b0; gs_seen <= 1'b0;
      code_q <= '0; defb_q <= '0; has_def_q <= 1'b0; len_q <= '0;
      start_ack <= 1'b0; start_nack <= 1'b0;
      st_overflow <= 1'b0; st_proto_err <= 1'b0; st_buf_unavail <= 1'b0;
    end else begin
      start_ack  <= 1'b0;
      start_nack <= 1'b0;

      if (ev_start) begin
        if (admit) begin
          active <= 1'b1; dir_q <= ev_directed; code_q <= ev_code;
          defb_q <= '0; has_def_q <= 1'b0; len_q <= '0; drop_q <= 1'b0;
          start_ack <= 1'b1;
        end else begin
          active     <= 1'b0;
          start_nack <= ev_directed;
        end
      end else if (ev_stop) begin
        active <= 1'b0;
      end else begin
        if (rx_push) len_q <= len_q + 1'b1;
        if (active && !drop_q && dir_q && ev_def_valid && !ev_parity_err) begin
          defb_q    <= ev_byte;
          has_def_q <= 1'b1;
        end
        if (perr_hit || ovf_hit) drop_q <= 1'b1;
      end

      if (bufna_set)     st_buf_unavail <= 1'b1;
      else if (space_ok) st_buf_unavail <= 1'b0;

      if (lock && ev_getstatus) gs_seen <= 1'b1;
      if (sw_resume && gs_seen) begin
        st_overflow  <= 1'b0;
        st_proto_err <= 1'b0;
        gs_seen      <= 1'b0;
      end
      if (ovf_hit)  st_overflow  <= 1'b1;
      if (perr_hit) st_proto_err <= 1'b1;
    end
  end

  AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && lock) |=> !start_ack); // R6
  AST_SPACE_GATES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !space_ok) |=> !start_ack); // R1
  AST_BCAST_NO_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_directed) |=> !start_nack); // R2
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_overflow) |-> $past(sw_resume)); // R6
  AST_RESP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    resp_push |-> !resp_full); // R7
endmodule

// File: rtl/vrx_wccc_rx.sv
module vrx_wccc_rx
  import vrx_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int RESP_DEPTH = 4,
  localparam int LW = $clog2(RX_DEPTH + 1),
  localparam int LEN_W = VRX_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_directed,
  input  logic [7:0]       ev_code,
  input  logic             ev_def_valid,
  input  logic             ev_byte_valid,
  input  logic [7:0]       ev_byte,
  input  logic             ev_parity_err,
  input  logic             ev_stop,
  input  logic             ev_getstatus,
  input  logic             sw_resume,
  input  logic [LW-1:0]    cfg_start_thld,
  input  logic [LW-1:0]    cfg_rx_thld,
  output logic             start_ack,
  output logic             start_nack,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [7:0]       resp_code,
  output logic [7:0]       resp_defb,
  output logic             resp_has_def,
  output logic [LEN_W-1:0] resp_len,
  output logic             st_overflow,
  output logic             st_proto_err,
  output logic             st_buf_unavail,
  output logic             dma_req
);
  localparam int RLW = $clog2(RESP_DEPTH + 1);

  logic          rx_push, rx_full, resp_push, resp_full;
  logic [7:0]    rx_din;
  logic [LW-1:0] rx_level;
  logic [RLW-1:0] resp_level;
  vrx_resp_t     resp_din, resp_head;

  vrx_admit #(.RX_DEPTH(RX_DEPTH)) ctl_i (
    .clk, .rst_n, .ev_start, .ev_directed, .ev_code, .ev_def_valid,
    .ev_byte_valid, .ev_byte, .ev_parity_err, .ev_stop, .ev_getstatus,
    .sw_resume, .cfg_start_thld, .rx_level, .rx_full, .resp_full,
    .rx_push, .rx_din, .resp_push, .resp_din, .start_ack, .start_nack,
    .st_overflow, .st_proto_err, .st_buf_unavail
  );

  vrx_fifo #(.W(8), .DEPTH(RX_DEPTH)) rxq_i (
    .clk, .rst_n, .push(rx_push), .din(rx_din), .full(rx_full),
    .valid(rx_valid), .ready(rx_ready), .dout(rx_data), .level(rx_level)
  );

  vrx_fifo #(.W(VRX_RESP_W), .DEPTH(RESP_DEPTH)) rspq_i (
    .clk, .rst_n, .push(resp_push), .din(resp_din), .full(resp_full),
    .valid(resp_valid), .ready(resp_ready), .dout(resp_head), .level(resp_level)
  );

  assign resp_code    = resp_head.code;
  assign resp_defb    = resp_head.defb;
  assign resp_has_def = resp_head.has_def;
  assign resp_len     = resp_head.len;
  assign dma_req      = (rx_level >= cfg_rx_thld);

  AST_RESP_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    resp_level <= RLW'(RESP_DEPTH)); // R11
endmodule

// File: tb/vrx_wccc_rx_tb.sv
module vrx_wccc_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic ev_start = 0, ev_directed = 0, ev_def_valid = 0, ev_byte_valid = 0;
  logic ev_parity_err = 0, ev_stop = 0, ev_getstatus = 0, sw_resume = 0;
  logic [7:0] ev_code = 0, ev_byte = 0;
  logic [4:0] cfg_start_thld = 5'd1, cfg_rx_thld = 5'd16;
  logic start_ack, start_nack, rx_valid, rx_ready = 1, resp_valid, resp_ready = 1;
  logic [7:0] rx_data, resp_code, resp_defb;
  logic resp_has_def, st_overflow, st_proto_err, st_buf_unavail, dma_req;
  logic [11:0] resp_len;

  vrx_wccc_rx dut_i (.*);

  int checks = 0, errors = 0;
  logic [7:0]  exp_rx[$];
  logic [28:0] exp_resp[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitors: scoreboard compare on handshake
  always @(negedge clk) if (rst_n && rx_valid && rx_ready) begin
    if (exp_rx.size() == 0) chk(0, "R10 unexpected rx byte", rx_data, 0);
    else begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      chk(rx_data == e, "R10 rx byte order", rx_data, e);
    end
  end
  always @(negedge clk) if (rst_n && resp_valid && resp_ready) begin
    logic [28:0] a;
    a = {resp_code, resp_defb, resp_has_def, resp_len};
    if (exp_resp.size() == 0) chk(0, "R11 unexpected response", a, 0);
    else begin
      logic [28:0] e;
      e = exp_resp.pop_front();
      chk(a == e, "R7 response entry", a, e);
    end
  end

  task automatic tick(); @(posedge clk); #1ns; endtask

  // kind: 0 ack, 1 nack, 2 silent
  task automatic do_start(input bit dir, input logic [7:0] code, input int kind, input string req);
    ev_start = 1; ev_directed = dir; ev_code = code;
    tick(); ev_start = 0;
    @(negedge clk);
    chk(start_ack == (kind == 0), {req, " ack"}, start_ack, kind == 0);
    chk(start_nack == (kind == 1), {req, " nack"}, start_nack, kind == 1);
    tick();
  endtask

  task automatic do_byte(input logic [7:0] b, input bit perr, input bit store);
    ev_byte_valid = 1; ev_byte = b; ev_parity_err = perr;
    if (store) exp_rx.push_back(b);
    tick(); ev_byte_valid = 0; ev_parity_err = 0;
  endtask

  task automatic do_def(input logic [7:0] b, input bit store);
    ev_def_valid = 1; ev_byte = b;
    if (store) exp_rx.push_back(b);
    tick(); ev_def_valid = 0;
  endtask

  task automatic do_pulse(input int which);
    if (which == 0) ev_stop = 1; else if (which == 1) ev_getstatus = 1; else sw_resume = 1;
    tick(); ev_stop = 0; ev_getstatus = 0; sw_resume = 0;
  endtask

  task automatic exp_r(input logic [7:0] c, input logic [7:0] d, input bit h, input int n);
    exp_resp.push_back({c, d, h, 12'(n)});
  endtask

  task automatic wait_n(input int n); repeat (n) tick(); endtask

  bit done = 0;
  initial begin
    #400us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3); rst_n = 1; tick();
    // reset state
    chk(!rx_valid && !resp_valid, "R10 reset empty", rx_valid, 0);
    chk(!st_overflow && !st_proto_err && !st_buf_unavail, "R3 reset status", st_buf_unavail, 0);
    chk(!start_ack && !start_nack, "R1 reset ack", start_ack, 0);

    // directed with defining byte (R1, R7)
    do_start(1, 8'h5A, 0, "R1 directed accept");
    do_def(8'h11, 0);
    do_byte(8'hA0, 0, 1); do_byte(8'hA1, 0, 1); do_byte(8'hA2, 0, 1);
    exp_r(8'h5A, 8'h11, 1, 3); do_pulse(0); wait_n(8);

    // broadcast with defining byte (R8)
    do_start(0, 8'h66, 0, "R8 broadcast accept");
    do_def(8'h22, 1); do_byte(8'hB0, 0, 1); do_byte(8'hB1, 0, 1);
    exp_r(8'h66, 8'h00, 0, 3); do_pulse(0); wait_n(8);

    // DMA threshold and stall hold (R9, R10)
    rx_ready = 0; cfg_rx_thld = 5'd4;
    do_start(1, 8'h70, 0, "R9 accept");
    do_byte(8'hC0, 0, 1); do_byte(8'hC1, 0, 1); do_byte(8'hC2, 0, 1);
    chk(dma_req == 0, "R9 dma below thld", dma_req, 0);
    do_byte(8'hC3, 0, 1);
    chk(dma_req == 1, "R9 dma at thld", dma_req, 1);
    wait_n(3);
    chk(rx_valid && rx_data == 8'hC0, "R10 stall hold", rx_data, 8'hC0);
    exp_r(8'h70, 0, 0, 4); do_pulse(0);
    rx_ready = 1; wait_n(8);
    chk(dma_req == 0, "R9 dma after drain", dma_req, 0);
    cfg_rx_thld = 5'd16;

    // buffer unavailable (R3, R2)
    rx_ready = 0; cfg_start_thld = 5'd8;
    do_start(1, 8'h31, 0, "R3 fill accept");
    for (int i = 0; i < 12; i++) do_byte(8'(8'h40 + i), 0, 1);
    exp_r(8'h31, 0, 0, 12); do_pulse(0);
    do_start(1, 8'h32, 1, "R3 directed low space");
    chk(st_buf_unavail == 1, "R3 bufna set", st_buf_unavail, 1);
    do_start(0, 8'h33, 2, "R2 broadcast ignored");
    do_byte(8'hEE, 0, 0); do_byte(8'hEF, 0, 0); do_pulse(0);
    chk(st_buf_unavail == 1, "R3 bufna held", st_buf_unavail, 1);
    rx_ready = 1; wait_n(20);
    chk(st_buf_unavail == 0, "R3 bufna cleared", st_buf_unavail, 0);
    do_start(1, 8'h34, 0, "R3 accept after space");
    exp_r(8'h34, 0, 0, 0); do_pulse(0); wait_n(4);

    // overflow and lockout (R4, R6)
    rx_ready = 0; cfg_start_thld = 5'd1;
    do_start(1, 8'h50, 0, "R4 accept");
    for (int i = 0; i < 16; i++) do_byte(8'(i), 0, 1);
    chk(st_overflow == 0, "R4 no ovf at full", st_overflow, 0);
    do_byte(8'hF0, 0, 0);
    chk(st_overflow == 1, "R4 ovf set", st_overflow, 1);
    do_byte(8'hF1, 0, 0);
    exp_r(8'h50, 0, 0, 16); do_pulse(0);
    rx_ready = 1; wait_n(20);
    do_start(1, 8'h51, 1, "R6 locked nack");
    do_pulse(2); tick();
    chk(st_overflow == 1, "R6 resume before status read", st_overflow, 1);
    do_pulse(1);
    chk(st_overflow == 1, "R6 status read alone", st_overflow, 1);
    do_pulse(2);
    chk(st_overflow == 0, "R6 cleared", st_overflow, 0);
    do_start(1, 8'h52, 0, "R6 accept after resume");
    exp_r(8'h52, 0, 0, 0); do_pulse(0); wait_n(4);

    // parity error (R5)
    do_start(1, 8'h60, 0, "R5 accept");
    do_def(8'h33, 0); do_byte(8'hA1, 0, 1);
    do_byte(8'hA2, 1, 0);
    chk(st_proto_err == 1, "R5 proto set", st_proto_err, 1);
    do_byte(8'hA3, 0, 0);
    exp_r(8'h60, 8'h33, 1, 1); do_pulse(0);
    do_start(0, 8'h61, 2, "R6 broadcast locked");
    do_pulse(1); do_pulse(2);
    chk(st_proto_err == 0, "R5 proto cleared", st_proto_err, 0);
    wait_n(4);

    // response queue full (R1, R11)
    resp_ready = 0;
    for (int i = 0; i < 4; i++) begin
      do_start(1, 8'(8'h80 + i), 0, "R11 fill resp");
      do_byte(8'(8'h90 + i), 0, 1);
      exp_r(8'(8'h80 + i), 0, 0, 1); do_pulse(0);
    end
    do_start(1, 8'h88, 1, "R1 resp full nack");
    chk(st_buf_unavail == 0, "R1 resp full no bufna", st_buf_unavail, 0);
    chk(resp_valid && resp_code == 8'h80, "R11 resp stall hold", resp_code, 8'h80);
    resp_ready = 1; wait_n(10);

    chk(exp_rx.size() == 0, "R10 all bytes seen", exp_rx.size(), 0);
    chk(exp_resp.size() == 0, "R7 all responses seen", exp_resp.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule